// File: doc/BRIEF.md
# SPI Master Pad Timing Skew Adjuster

This block sits between the SPI master's shift engine and the I/O pads and trims the timing of the serial paths in whole core-clock cycles. The outgoing data bit can be held back by up to three cycles before it reaches the pad. The incoming data bit can also be held back by up to three cycles before it reaches the shift engine. A third setting moves the receive capture strobe so that the engine samples earlier or later than its nominal point.

Early sampling has to be possible, so the block defines the nominal sample point as the incoming strobe delayed by two cycles. The "early" settings tap the strobe pipeline before that point and the "late" setting taps it after. The three 2-bit codes come in on plain control pins. A shadow register captures them only while no transfer is in progress, so a reprogram during a frame cannot shift bits in the middle of that frame.

Every path advances on every core cycle. There is no handshake and no back-pressure: each pin carries one bit per cycle, and the block never stalls or drops one.

Top module: `spi_io_skew_adjust`

## Requirements
- R1: After reset all three applied codes are 0: `mosi_pad` follows `mosi_core` and `miso_core` follows `miso_pad` within the same cycle, and `strobe_capture` equals `strobe_nominal` in the same cycle (capture two cycles early).
- R2: With applied output code n (0 to 3), `mosi_pad` equals the value `mosi_core` had n core cycles earlier.
- R3: With applied input code n (0 to 3), `miso_core` equals the value `miso_pad` had n core cycles earlier.
- R4: Capture code 0 (two cycles early) makes `strobe_capture` equal `strobe_nominal` of the same cycle.
- R5: Capture code 1 (one cycle early) makes `strobe_capture` equal `strobe_nominal` of one cycle earlier.
- R6: Capture code 2 (nominal point) makes `strobe_capture` equal `strobe_nominal` of two cycles earlier.
- R7: Capture code 3 (one cycle late) makes `strobe_capture` equal `strobe_nominal` of three cycles earlier.
- R8: Code inputs are sampled only on clock edges where `xfer_active` is low, and they take effect from the following cycle. While `xfer_active` is high, code changes have no effect on any output.
- R9: Reset clears every delay stage to 0, so a delayed tap reads 0 until post-reset values reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | High while a transfer is in progress; freezes the applied codes |
| mosi_dly_code | input | 2 | Output delay code: 0..3 cycles |
| miso_dly_code | input | 2 | Input delay code: 0..3 cycles |
| capture_code | input | 2 | 0: 2 early, 1: 1 early, 2: nominal, 3: 1 late |
| mosi_core | input | 1 | Serial output bit from the shift engine |
| miso_pad | input | 1 | Raw serial input bit from the pad |
| strobe_nominal | input | 1 | Sample event from the shift engine |
| mosi_pad | output | 1 | Delayed serial output bit to the pad |
| miso_core | output | 1 | Delayed serial input bit to the shift engine |
| strobe_capture | output | 1 | Adjusted capture strobe |

## Verification
The hardest situation to reach is a code change that arrives while a transfer is active and is then released. The outputs must keep the old delays during the whole frame and switch exactly one cycle after `xfer_active` falls. The stimulus gets there with a directed sequence that raises `xfer_active`, moves all three codes to their maximum, toggles the data for several cycles and then drops `xfer_active`. A randomized phase adds busy windows and code changes at random points, with the data history modelled on the bench side. A second directed case selects the deepest taps on the first cycle after reset, so the outputs read the cleared stages before any real data has arrived.

// File: rtl/spi_skew_pkg.sv
package spi_skew_pkg;
  localparam int unsigned CODE_W      = 2;
  localparam int unsigned MAX_TAP     = (1 << CODE_W) - 1;
  localparam int unsigned NOMINAL_TAP = 2;

  typedef logic [CODE_W-1:0] skew_code_t;

  typedef struct packed {
    skew_code_t out_dly;
    skew_code_t in_dly;
    skew_code_t cap_sel;
  } skew_cfg_t;
endpackage

// File: rtl/skew_cfg_shadow.sv
module skew_cfg_shadow
  import spi_skew_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  skew_cfg_t cfg_in,
  output skew_cfg_t cfg_q
);
  // Codes only move between transfers so a frame keeps one timing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!hold) begin
      cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/skew_tap_line.sv
module skew_tap_line #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned DEPTH = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  // stage[k] holds din from k cycles earlier
  logic [DEPTH:1] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      stage[1] <= din;
      for (int k = 2; k <= DEPTH; k++) begin
        stage[k] <= stage[k-1];
      end
    end
  end

  always_comb begin
    if (sel == '0) dout = din;
    else           dout = stage[sel];
  end
endmodule

// File: rtl/spi_io_skew_adjust.sv
module spi_io_skew_adjust
  import spi_skew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_active,
  input  logic [1:0] mosi_dly_code,
  input  logic [1:0] miso_dly_code,
  input  logic [1:0] capture_code,
  input  logic       mosi_core,
  input  logic       miso_pad,
  input  logic       strobe_nominal,
  output logic       mosi_pad,
  output logic       miso_core,
  output logic       strobe_capture
);
  skew_cfg_t cfg_req, cfg_q;

  assign cfg_req = '{out_dly: mosi_dly_code, in_dly: miso_dly_code, cap_sel: capture_code};

  skew_cfg_shadow u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (xfer_active),
    .cfg_in(cfg_req),
    .cfg_q (cfg_q)
  );

  skew_tap_line #(.SEL_W(CODE_W)) u_out_line (
    .clk(clk), .rst_n(rst_n), .din(mosi_core), .sel(cfg_q.out_dly), .dout(mosi_pad)
  );

  skew_tap_line #(.SEL_W(CODE_W)) u_in_line (
    .clk(clk), .rst_n(rst_n), .din(miso_pad), .sel(cfg_q.in_dly), .dout(miso_core)
  );

  // Nominal capture sits NOMINAL_TAP stages down, so lower codes fire early.
  skew_tap_line #(.SEL_W(CODE_W)) u_cap_line (
    .clk(clk), .rst_n(rst_n), .din(strobe_nominal), .sel(cfg_q.cap_sel), .dout(strobe_capture)
  );

  // Cycles since reset, saturating, so history checks never reach before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_mosi_tap3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && cfg_q.out_dly == 2'd3) |-> mosi_pad == $past(mosi_core, 3));

  p_miso_tap1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && cfg_q.in_dly == 2'd1) |-> miso_core == $past(miso_pad));

  p_cap_nominal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && cfg_q.cap_sel == 2'd2) |-> strobe_capture == $past(strobe_nominal, 2));

  p_cap_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && cfg_q.cap_sel == 2'd3) |-> strobe_capture == $past(strobe_nominal, 3));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |=> cfg_q == $past(cfg_q));
endmodule

// File: tb/sim_spi_io_skew_adjust.sv
module sim_spi_io_skew_adjust;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_active = 1'b0;
  logic [1:0] mosi_dly_code = '0, miso_dly_code = '0, capture_code = '0;
  logic mosi_core = 1'b0, miso_pad = 1'b0, strobe_nominal = 1'b0;
  logic mosi_pad, miso_core, strobe_capture;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model: applied codes and input history (bit d = d cycles ago)
  logic [1:0] m_mo = '0, m_mi = '0, m_cap = '0;
  logic [3:0] h_mo = '0, h_mi = '0, h_st = '0;

  always #2.5 clk = ~clk;

  spi_io_skew_adjust u0 (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
    .mosi_dly_code(mosi_dly_code), .miso_dly_code(miso_dly_code), .capture_code(capture_code),
    .mosi_core(mosi_core), .miso_pad(miso_pad), .strobe_nominal(strobe_nominal),
    .mosi_pad(mosi_pad), .miso_core(miso_core), .strobe_capture(strobe_capture)
  );

  task automatic check(string tag, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string cap_tag(logic [1:0] c);
    case (c)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // One cycle: drive at negedge, check shortly after, update model for next edge.
  task automatic step(logic mo, logic mi, logic st, logic busy,
                      logic [1:0] c_mo, logic [1:0] c_mi, logic [1:0] c_cap);
    @(negedge clk);
    mosi_core = mo; miso_pad = mi; strobe_nominal = st; xfer_active = busy;
    mosi_dly_code = c_mo; miso_dly_code = c_mi; capture_code = c_cap;
    h_mo = {h_mo[2:0], mo};
    h_mi = {h_mi[2:0], mi};
    h_st = {h_st[2:0], st};
    #1;
    check("R2", mosi_pad, h_mo[m_mo]);
    check("R3", miso_core, h_mi[m_mi]);
    check(cap_tag(m_cap), strobe_capture, h_st[m_cap]);
    if (!busy) begin
      m_mo = c_mo; m_mi = c_mi; m_cap = c_cap;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: pass-through while held in reset
    @(negedge clk);
    mosi_dly_code = 2'd3; miso_dly_code = 2'd3; capture_code = 2'd3;
    mosi_core = 1'b1; miso_pad = 1'b1; strobe_nominal = 1'b1;
    #1;
    check("R1", mosi_pad, 1'b1);
    check("R1", miso_core, 1'b1);
    check("R1", strobe_capture, 1'b1);
    @(negedge clk);
    mosi_core = 1'b0; miso_pad = 1'b1; strobe_nominal = 1'b0;
    #1;
    check("R1", mosi_pad, 1'b0);
    check("R1", miso_core, 1'b1);
    mosi_dly_code = '0; miso_dly_code = '0; capture_code = '0; miso_pad = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R9: deepest taps right after reset read cleared stages
    step(1, 1, 1, 0, 2'd3, 2'd3, 2'd3);
    step(1, 1, 1, 0, 2'd3, 2'd3, 2'd3);
    check("R9", mosi_pad, 1'b0);
    check("R9", miso_core, 1'b0);
    check("R9", strobe_capture, 1'b0);
    step(1, 1, 1, 0, 2'd3, 2'd3, 2'd3);
    check("R9", mosi_pad, 1'b0);
    step(0, 0, 0, 0, 2'd0, 2'd0, 2'd0);

    // R8: codes change while busy, must stay at zero delay
    for (int i = 0; i < 6; i++) begin
      step(i[0], ~i[0], i[1], 1, 2'd3, 2'd3, 2'd3);
      check("R8", mosi_pad, mosi_core);
      check("R8", miso_core, miso_pad);
      check("R8", strobe_capture, strobe_nominal);
    end
    step(1, 0, 1, 0, 2'd3, 2'd3, 2'd3);
    check("R8", mosi_pad, mosi_core);
    step(0, 1, 0, 0, 2'd3, 2'd3, 2'd3);
    check("R8", mosi_pad, h_mo[3]);
    check("R8", strobe_capture, h_st[3]);

    // directed sweep of every capture code
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 8; i++) begin
        step(i[1], i[0], (i == 2), 0, c[1:0], c[1:0], c[1:0]);
      end
    end

    // randomized phase
    begin
      logic [1:0] r_mo = '0, r_mi = '0, r_cap = '0;
      logic busy = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 9) == 0) busy = ~busy;
        if ($urandom_range(0, 5) == 0) begin
          r_mo = 2'($urandom); r_mi = 2'($urandom); r_cap = 2'($urandom);
        end
        step(1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0), busy, r_mo, r_mi, r_cap);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule